// File: doc/BRIEF.md
# Receive Descriptor Prefetch Cache

This block holds a small local copy of receive descriptors taken from a ring that lives in host memory. Packet-store logic is its consumer. It asks for the current descriptor with a get, fills the descriptor in, and hands it back with a put. The block answers gets from the local copy. When the copy is used up, it refills the copy with burst read requests, and it issues one write-back request for each descriptor handed back.

A get only looks at the entry under the current index. The index moves forward only on a put, so it always names the same slot that the ring head names. Each accepted put raises a head-advance strobe to the ring pointer logic, which owns the head register. A refill covers as many descriptors as the cache can hold, capped by the number of ring entries between head and tail. If the refill would run past the last ring entry, it goes out as two reads: the first reaches the end of the ring and the second starts again at ring index 0.

Top module: `rx_desc_cache`

## Requirements
- R1: After `rstN` is low, or while `rxEnable` is low, the cache is empty. The next put is refused and the next get starts a new fetch at the ring head. After reset, `getDone`, `wbValid`, `rdReqValid` and `headAdvance` are all 0.
- R2: A get that finds an unconsumed entry pulses `getDone` with `getOk`=1 one cycle later and returns that entry on `getDesc`. It does not advance the index, so two gets with no put between them return the same descriptor.
- R3: A get that finds the cache used up clears the index and the fetched count. It then fetches min(CACHE_DEPTH, avail) descriptors, where avail = (ringTail − ringHead) mod ringSize. Once the fill completes it pulses `getDone` with `getOk`=1 and returns the descriptor at ring index `ringHead`.
- R4: If a get finds the cache used up and avail is 0, `getDone` pulses with `getOk`=0 and no read is requested.
- R5: A put while an unconsumed entry is present raises `headAdvance` in that same cycle. In the next cycle it raises `wbValid` for one cycle, with `wbAddr` = base + 16·ringHead (ringHead sampled in the put cycle) and `wbData` = `putDesc`.
- R6: The ring base address is `ringBaseHi` in bits 63:32 and `ringBaseLo` in bits 31:0. Every read and write-back address is formed from this base.
- R7: Each read request names a start address base + 16·i and a count `rdReqCount` with 1 ≤ count ≤ CACHE_DEPTH and i + count ≤ ringSize. The request is held steady until `rdReqReady`. A refill that would pass the ring end becomes two requests, and the second one starts at ring index 0.
- R8: A put while the cache holds no unconsumed entry, or while a fetch is in progress, raises no `headAdvance` and no `wbValid`. It pulses `putErr` one cycle later.
- R9: When a get and a put arrive in the same cycle, the put is applied first. The get then sees the following entry, or, if the put consumed the last entry, a fresh fetch that starts at the already advanced head.
- R10: Response beats on `rdRspValid`/`rdRspData` fill the cache in request order. Successive gets therefore return the descriptors of successive ring indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receive path enable; low empties the cache |
| ringBaseHi | input | 32 | Ring base address, upper half |
| ringBaseLo | input | 32 | Ring base address, lower half |
| ringSize | input | IDX_W | Number of descriptors in the ring |
| ringHead | input | IDX_W | Ring head index from the ring pointer logic |
| ringTail | input | IDX_W | Ring tail index |
| getReq | input | 1 | Get request, one cycle |
| getDone | output | 1 | Get answered |
| getOk | output | 1 | With getDone: a descriptor is available |
| getDesc | output | 128 | Current descriptor |
| putReq | input | 1 | Put request, one cycle |
| putDesc | input | 128 | Filled-in descriptor to write back |
| putErr | output | 1 | Put refused because no entry was held |
| headAdvance | output | 1 | Strobe to advance the ring head |
| wbValid | output | 1 | Write-back request |
| wbAddr | output | 64 | Write-back address |
| wbData | output | 128 | Write-back descriptor |
| rdReqValid | output | 1 | Burst read request |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | 64 | Read start address |
| rdReqCount | output | CNT_W | Descriptors in the read |
| rdRspValid | input | 1 | Read response beat |
| rdRspData | input | 128 | One descriptor per beat |

## Verification
Two of this block's functions can fall in the same cycle: a put that advances the index and a get that peeks at it. The bench provokes this by driving both requests in one cycle on every other ring position it sweeps. This covers the case where the put leaves entries behind and the case where it consumes the last cached entry, which forces a refill. Each such step is judged on two counts: the write-back must carry the head from before the advance, and the descriptor returned must be the one at the advanced head.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;
  localparam int DESC_W     = 128;
  localparam int DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int ADDR_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_RD1, ST_RD2, ST_FILL
  } fetchState_t;

  typedef struct packed {
    logic clearPtrs;
    logic stepIdx;
    logic takeBeat;
    logic latchPlan;
    logic showHit;
    logic pickSecond;
  } dpCtl_t;
endpackage

// File: rtl/rxdc_datapath.sv
module rxdc_datapath
  import rxdc_pkg::*;
#(
  parameter int CACHE_DEPTH = 4,
  parameter int IDX_W       = 8,
  localparam int CNT_W      = $clog2(CACHE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [IDX_W-1:0]  ringHead,
  input  logic [IDX_W-1:0]  ringTail,
  input  logic [IDX_W-1:0]  ringSize,
  input  logic [DESC_W-1:0] putDesc,
  input  logic [DESC_W-1:0] rspData,
  output logic              nonEmpty,
  output logic              lastEntry,
  output logic              fillDone,
  output logic              planEmpty,
  output logic              planSplit,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [CNT_W-1:0]  reqCount,
  output logic [DESC_W-1:0] getDesc,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DESC_W-1:0] wbData
);
  localparam int PTR_W = $clog2(CACHE_DEPTH);
  localparam logic [IDX_W:0] DEPTH_EXT = (IDX_W + 1)'(CACHE_DEPTH);

  logic [DESC_W-1:0] cacheMem [CACHE_DEPTH];
  logic [CNT_W-1:0]  curIdx, fetchCnt, planTotal, planFirst, idxSel;
  logic [ADDR_W-1:0] planAddr, headAddr;
  logic [IDX_W:0]    avail, toEnd, totalCalc, firstCalc;

  // ring occupancy and distance to the ring end
  always_comb begin
    if (ringTail >= ringHead) avail = {1'b0, ringTail} - {1'b0, ringHead};
    else avail = {1'b0, ringSize} - {1'b0, ringHead} + {1'b0, ringTail};
    toEnd     = {1'b0, ringSize} - {1'b0, ringHead};
    totalCalc = (avail < DEPTH_EXT) ? avail : DEPTH_EXT;
    firstCalc = (totalCalc > toEnd) ? toEnd : totalCalc;
  end

  assign headAddr  = ringBase + (ADDR_W'(ringHead) << DESC_SHIFT);
  assign nonEmpty  = curIdx < fetchCnt;
  assign lastEntry = ({1'b0, curIdx} + 1'b1) == {1'b0, fetchCnt};
  assign fillDone  = fetchCnt == planTotal;
  assign planEmpty = planTotal == '0;
  assign planSplit = planFirst != planTotal;
  assign reqAddr   = ctl.pickSecond ? ringBase : planAddr;
  assign reqCount  = ctl.pickSecond ? planTotal - planFirst : planFirst;
  assign idxSel    = ctl.stepIdx ? curIdx + 1'b1 : curIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      fetchCnt  <= '0;
      planTotal <= '0;
      planFirst <= '0;
      planAddr  <= '0;
    end else begin
      if (ctl.clearPtrs) begin
        curIdx   <= '0;
        fetchCnt <= '0;
      end else begin
        if (ctl.stepIdx)  curIdx   <= curIdx + 1'b1;
        if (ctl.takeBeat) fetchCnt <= fetchCnt + 1'b1;
      end
      if (ctl.latchPlan) begin
        planTotal <= CNT_W'(totalCalc);
        planFirst <= CNT_W'(firstCalc);
        planAddr  <= headAddr;
      end
    end
  end

  // one storage slot per cache entry
  for (genvar s = 0; s < CACHE_DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctl.takeBeat && fetchCnt[PTR_W-1:0] == PTR_W'(s))
        cacheMem[s] <= rspData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      getDesc <= '0;
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else begin
      if (ctl.showHit) getDesc <= cacheMem[idxSel[PTR_W-1:0]];
      wbValid <= ctl.stepIdx;
      if (ctl.stepIdx) begin
        wbAddr <= headAddr;
        wbData <= putDesc;
      end
    end
  end
endmodule

// File: rtl/rxdc_control.sv
module rxdc_control
  import rxdc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEnable,
  input  logic   getReq,
  input  logic   putReq,
  input  logic   nonEmpty,
  input  logic   lastEntry,
  input  logic   fillDone,
  input  logic   planEmpty,
  input  logic   planSplit,
  input  logic   rdReqReady,
  input  logic   rdRspValid,
  output dpCtl_t ctl,
  output logic   rdReqValid,
  output logic   headAdvance,
  output logic   getDone,
  output logic   getOk,
  output logic   putErr
);
  fetchState_t state, stateNext;
  logic idle, putOk, getHit, getMiss, fillFinish, noneFinish, fetching;

  assign idle       = rxEnable && (state == ST_IDLE);
  assign putOk      = putReq && idle && nonEmpty;
  assign getHit     = getReq && idle && (putOk ? !lastEntry : nonEmpty);
  assign getMiss    = getReq && idle && !getHit;
  assign fillFinish = rxEnable && (state == ST_FILL) && fillDone;
  assign noneFinish = rxEnable && (state == ST_RD1) && planEmpty;
  assign fetching   = (state == ST_RD1) || (state == ST_RD2) || (state == ST_FILL);

  assign headAdvance = putOk;
  assign rdReqValid  = ((state == ST_RD1) && !planEmpty) || (state == ST_RD2);

  always_comb begin
    ctl.clearPtrs  = !rxEnable || getMiss;
    ctl.stepIdx    = putOk;
    ctl.takeBeat   = rxEnable && rdRspValid && fetching && !fillDone;
    ctl.latchPlan  = state == ST_PLAN;
    ctl.showHit    = getHit || fillFinish;
    ctl.pickSecond = state == ST_RD2;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (getMiss) stateNext = ST_PLAN;
      ST_PLAN: stateNext = ST_RD1;
      ST_RD1: begin
        if (planEmpty) stateNext = ST_IDLE;
        else if (rdReqReady) stateNext = planSplit ? ST_RD2 : ST_FILL;
      end
      ST_RD2:  if (rdReqReady) stateNext = ST_FILL;
      ST_FILL: if (fillDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (!rxEnable) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      getDone <= 1'b0;
      getOk   <= 1'b0;
      putErr  <= 1'b0;
    end else begin
      state   <= stateNext;
      getDone <= getHit || fillFinish || noneFinish;
      getOk   <= getHit || fillFinish;
      putErr  <= putReq && rxEnable && !putOk;
    end
  end
endmodule

// File: rtl/rx_desc_cache.sv
module rx_desc_cache
  import rxdc_pkg::*;
#(
  parameter int CACHE_DEPTH = 4,
  parameter int IDX_W       = 8,
  localparam int CNT_W      = $clog2(CACHE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic [31:0]       ringBaseHi,
  input  logic [31:0]       ringBaseLo,
  input  logic [IDX_W-1:0]  ringSize,
  input  logic [IDX_W-1:0]  ringHead,
  input  logic [IDX_W-1:0]  ringTail,
  input  logic              getReq,
  output logic              getDone,
  output logic              getOk,
  output logic [127:0]      getDesc,
  input  logic              putReq,
  input  logic [127:0]      putDesc,
  output logic              putErr,
  output logic              headAdvance,
  output logic              wbValid,
  output logic [63:0]       wbAddr,
  output logic [127:0]      wbData,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [63:0]       rdReqAddr,
  output logic [CNT_W-1:0]  rdReqCount,
  input  logic              rdRspValid,
  input  logic [127:0]      rdRspData
);
  dpCtl_t ctl;
  logic nonEmpty, lastEntry, fillDone, planEmpty, planSplit;
  logic [63:0] ringBase;

  assign ringBase = {ringBaseHi, ringBaseLo};

  rxdc_control u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .getReq(getReq), .putReq(putReq),
    .nonEmpty(nonEmpty), .lastEntry(lastEntry), .fillDone(fillDone),
    .planEmpty(planEmpty), .planSplit(planSplit), .rdReqReady(rdReqReady),
    .rdRspValid(rdRspValid), .ctl(ctl), .rdReqValid(rdReqValid),
    .headAdvance(headAdvance), .getDone(getDone), .getOk(getOk), .putErr(putErr)
  );

  rxdc_datapath #(.CACHE_DEPTH(CACHE_DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ringBase(ringBase), .ringHead(ringHead),
    .ringTail(ringTail), .ringSize(ringSize), .putDesc(putDesc), .rspData(rdRspData),
    .nonEmpty(nonEmpty), .lastEntry(lastEntry), .fillDone(fillDone),
    .planEmpty(planEmpty), .planSplit(planSplit), .reqAddr(rdReqAddr),
    .reqCount(rdReqCount), .getDesc(getDesc), .wbValid(wbValid), .wbAddr(wbAddr),
    .wbData(wbData)
  );
endmodule

// File: rtl/rx_desc_cache_checker.sv
module rx_desc_cache_checker #(
  parameter int CACHE_DEPTH = 4,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxEnable,
  input logic             putReq,
  input logic             putErr,
  input logic             headAdvance,
  input logic             wbValid,
  input logic             getDone,
  input logic             rdReqValid,
  input logic             rdReqReady,
  input logic [63:0]      rdReqAddr,
  input logic [CNT_W-1:0] rdReqCount
);
  // R5: an accepted put is followed by exactly one write-back
  assert_put_writes_back_R5: assert property (@(posedge clk) disable iff (!rstN)
    headAdvance |=> wbValid);

  // R7: read burst length stays within the cache
  assert_read_count_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid |-> (rdReqCount != '0) && (rdReqCount <= CNT_W'(CACHE_DEPTH)));

  // R7: a pending read is held steady until accepted
  assert_read_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady && rxEnable) |=> (rdReqValid && $stable(rdReqAddr)));

  // R8: a refusal only follows a put request
  assert_err_needs_put_R8: assert property (@(posedge clk) disable iff (!rstN)
    putErr |-> $past(putReq));

  // R3: a get is answered only once no read is outstanding
  assert_done_after_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    getDone |-> !rdReqValid);
endmodule

bind rx_desc_cache rx_desc_cache_checker #(.CACHE_DEPTH(CACHE_DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .putReq(putReq), .putErr(putErr),
  .headAdvance(headAdvance), .wbValid(wbValid), .getDone(getDone),
  .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
  .rdReqCount(rdReqCount)
);

// File: tb/tb_rx_desc_cache.sv
`timescale 1ns/1ps
module tb_rx_desc_cache;
  localparam int DEPTH = 4;
  localparam int IDXW  = 8;
  localparam int CNTW  = $clog2(DEPTH + 1);
  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

  logic clk = 0, rstN = 0, rxEnable = 0;
  logic [IDXW-1:0] ringSize = 8'd3, ringHead = 0, ringTail = 0;
  logic getReq = 0, putReq = 0;
  logic [127:0] putDesc = 0;
  logic getDone, getOk, putErr, headAdvance, wbValid, rdReqValid;
  logic [127:0] getDesc, wbData;
  logic [63:0] wbAddr, rdReqAddr;
  logic [CNTW-1:0] rdReqCount;
  logic rdReqReady = 0, rdRspValid = 0;
  logic [127:0] rdRspData = 0;
  logic loadHead = 0;
  logic [IDXW-1:0] newHead = 0;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_desc_cache #(.CACHE_DEPTH(DEPTH), .IDX_W(IDXW)) dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .ringBaseHi(BASE[63:32]),
    .ringBaseLo(BASE[31:0]), .ringSize(ringSize), .ringHead(ringHead),
    .ringTail(ringTail), .getReq(getReq), .getDone(getDone), .getOk(getOk),
    .getDesc(getDesc), .putReq(putReq), .putDesc(putDesc), .putErr(putErr),
    .headAdvance(headAdvance), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdReqCount(rdReqCount), .rdRspValid(rdRspValid), .rdRspData(rdRspData)
  );

  function automatic logic [127:0] descAt(input int idx);
    logic [63:0] a;
    a = BASE + 64'(idx) * 64'd16;
    return {a, ~a};
  endfunction

  task automatic check(input bit good, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!good) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ring pointer logic model
  always @(posedge clk) begin
    if (loadHead) ringHead <= newHead;
    else if (headAdvance) ringHead <= (ringHead + 1'b1 == ringSize) ? '0 : ringHead + 1'b1;
  end

  // host memory model: queued beats, ready toggles every cycle
  logic [63:0] memQ [64];
  int qWr = 0, qRd = 0;
  always @(posedge clk) begin
    rdReqReady <= ~rdReqReady;
    if (qRd != qWr) begin
      rdRspValid <= 1'b1;
      rdRspData  <= {memQ[qRd % 64], ~memQ[qRd % 64]};
      qRd++;
    end else rdRspValid <= 1'b0;
    if (rstN && rdReqValid && rdReqReady) begin
      for (int k = 0; k < int'(rdReqCount); k++) begin
        memQ[qWr % 64] = rdReqAddr + 64'(k) * 64'd16;
        qWr++;
      end
    end
  end

  // R7: every accepted read stays inside the ring and within the cache size
  always @(posedge clk) begin
    if (rstN && rdReqValid && rdReqReady) begin
      logic [63:0] off;
      off = rdReqAddr - BASE;
      check(off[3:0] == 0 && (off >> 4) + 64'(rdReqCount) <= 64'(ringSize) &&
            rdReqCount >= 1 && int'(rdReqCount) <= DEPTH,
            "R7 read within ring", {off, 61'd0, rdReqCount}, {64'(ringSize), 64'(DEPTH)});
    end
  end

  task automatic waitDone(output bit ok, output logic [127:0] d);
    int w;
    w = 0;
    while (!getDone && w < 300) begin
      @(posedge clk); #1; w++;
    end
    check(getDone, "R3 get answered", {127'd0, getDone}, 128'd1);
    ok = getOk;
    d  = getDesc;
  endtask

  task automatic doGet(input bit withPut, input logic [127:0] pd,
                       output bit ok, output logic [127:0] d);
    logic [63:0] expWb;
    @(negedge clk);
    getReq = 1; putReq = withPut; putDesc = pd;
    expWb = BASE + 64'(ringHead) * 64'd16;
    #1;
    if (withPut) check(headAdvance, "R9 put applied with get", {127'd0, headAdvance}, 128'd1);
    @(posedge clk); #1;
    getReq = 0; putReq = 0;
    if (withPut)
      check(wbValid && wbAddr == expWb && wbData == pd, "R9 R6 write-back at old head",
            {wbAddr, 63'd0, wbValid}, {expWb, 64'd1});
    waitDone(ok, d);
  endtask

  task automatic doPut(input logic [127:0] pd);
    logic [63:0] expWb;
    @(negedge clk);
    putReq = 1; putDesc = pd;
    expWb = BASE + 64'(ringHead) * 64'd16;
    #1;
    check(headAdvance, "R5 head advance", {127'd0, headAdvance}, 128'd1);
    @(posedge clk); #1;
    putReq = 0;
    check(wbValid && wbAddr == expWb && wbData == pd, "R5 R6 write-back",
          {wbAddr, 63'd0, wbValid}, {expWb, 64'd1});
  endtask

  task automatic doPutErr(input string tag);
    @(negedge clk);
    putReq = 1; putDesc = '1;
    #1;
    check(!headAdvance, {tag, " no head advance"}, {127'd0, headAdvance}, 128'd0);
    @(posedge clk); #1;
    putReq = 0;
    check(putErr && !wbValid, {tag, " put refused"}, {126'd0, putErr, wbValid}, 128'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int sizes [3] = '{3, 6, 9};
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!getDone && !wbValid && !rdReqValid && !headAdvance, "R1 reset outputs",
          {124'd0, getDone, wbValid, rdReqValid, headAdvance}, 128'd0);
    @(negedge clk); rstN = 1;

    foreach (sizes[si]) begin
      for (int h = 0; h < sizes[si]; h++) begin
        for (int av = 0; av < sizes[si]; av++) begin
          bit ok, comb;
          logic [127:0] d, d2;
          int consumed;
          // disable, reposition ring, re-enable (R1)
          @(negedge clk);
          rxEnable = 0;
          ringSize = IDXW'(sizes[si]);
          ringTail = IDXW'((h + av) % sizes[si]);
          newHead  = IDXW'(h);
          loadHead = 1;
          @(negedge clk);
          loadHead = 0;
          rxEnable = 1;
          doPutErr("R1 R8 empty after disable");
          comb = (h % 2) == 1;
          consumed = 0;
          doGet(0, '0, ok, d);
          check(ok == (av > 0), "R3 R4 availability", {127'd0, ok}, {127'd0, av > 0});
          if (ok) begin
            check(d == descAt(int'(ringHead)), "R3 R10 first descriptor", d,
                  descAt(int'(ringHead)));
            doGet(0, '0, ok, d2);
            check(ok && d2 == d, "R2 repeat get unchanged", d2, d);
          end
          while (ok && consumed <= av) begin
            logic [127:0] pd;
            pd = {32'(si), 32'(h), 32'(av), 32'(consumed)};
            if (comb) begin
              doGet(1, pd, ok, d);
              consumed++;
            end else begin
              doPut(pd);
              consumed++;
              doGet(0, '0, ok, d);
            end
            check(ok == (consumed < av), "R3 R4 R9 remaining", {127'd0, ok},
                  {127'd0, consumed < av});
            if (ok)
              check(d == descAt(int'(ringHead)), "R9 R10 next descriptor", d,
                    descAt(int'(ringHead)));
          end
          check(consumed == av, "R3 consumed count", 128'(consumed), 128'(av));
          if (av == 0) doPutErr("R8 nothing held");
        end
      end
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule